// File: doc/BRIEF.md
# Configurable Signal Routing Matrix

This block is a crossbar, programmed through registers, that joins internal peripheral signals to a bank of external pads. Every routing destination owns a small selection field. The field holds a source code, and a combinational multiplexer uses that code to pick the one source that drives the destination. The destinations are the inputs of the peripherals, two pass-through nodes, the data input of every pad driver and the drive enable of every pad driver. Because a pad's data and its enable are ordinary destinations, any source can set a pad's level or direction. That includes the level seen on another pad, passed through one of the pass-through nodes.

Each pad has three logical terminals. The driver data goes out on `pad_out`. The enable goes out on `pad_oe`. The sensed level comes back on `pad_in`, which is the real level at the pad and is the only pad terminal the matrix reads. Software loads the selection fields through a simple synchronous register write port and reads them back through a combinational read path. Out of reset, the pads are connected to the peripheral signals rather than tied low.

Top module: `sig_route_matrix`

## Requirements
- R1: `pad_out[i]` equals the source chosen by the data field of pad i. `pad_oe[i]` equals the source chosen by the enable field of pad i. A data code of 0 gives `pad_out[i]`=0 and a code of 1 gives 1.
- R2: Every pad-level source seen inside the matrix is `pad_in[i]`, whatever the pad's direction. A destination routed to pad i follows the driven value while `pad_oe[i]`=1 and follows the outside level while `pad_oe[i]`=0.
- R3: Fields are 5 bits wide, six to a 32-bit register. Field k sits in bits [5k+4:5k]. Destination d lives in register d/6, field d%6. The destinations are numbered as follows: peripheral inputs 0–5, pass-through nodes 6–7, pad data 8–27, pad enables 28–47. Bits 31:30 always read 0.
- R4: A write takes effect at the clock edge on which `cfg_we` is sampled high, and not before. `cfg_rdata` returns the stored register at `cfg_addr`. With `cfg_we` low, no field changes.
- R5: Codes for peripheral-input destinations are as follows: 0 is low, 1 is high, 2–21 select pad (code−2), 22–27 select `periph_src[code−22]`, 28–29 select pass-through node (code−28), and 30–31 give low.
- R6: Codes for pad-data destinations are as follows: 0 is low, 1 is high, 2–7 select `periph_src[code−2]`, 8–9 select pass-through node (code−8), and 10–31 give low.
- R7: Codes for pad-enable destinations are as follows: 0 is low, 1 is high, 2–7 select `periph_src_en[code−2]`, 8–9 select pass-through node (code−8), and 10–31 give low.
- R8: A pass-through node outputs the source chosen by its field, using the R5 code set. The exception is codes 28–29, which give low, so a node can never select a node.
- R9: After reset, peripheral input j holds code 2+j, pad data i and pad enable i both hold code 2+(i mod 6), and both pass-through nodes hold 0.
- R10: One source may drive any number of destinations at the same time.
- R11: A pad's direction can follow another pad's level: with pad enable 7 set to node 0 and node 0 set to pad 1, `pad_oe[7]` tracks `pad_in[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Stored value of register `cfg_addr` |
| periph_src | input | 6 | Peripheral output signals |
| periph_src_en | input | 6 | Peripheral pad-enable outputs |
| periph_dst | output | 6 | Routed peripheral input signals |
| pad_in | input | 20 | Level sensed at each pad |
| pad_out | output | 20 | Driver data for each pad |
| pad_oe | output | 20 | Driver enable for each pad |

## Verification
A register write presented after a falling edge is stored at the next rising edge. Every routed output then settles combinationally, so the bench checks each result 1 ns after the following falling edge. The bench also checks once, 1 ns after presenting a write, that the stored value has not yet moved. Changes on the pad or peripheral inputs reach the outputs in the same cycle with no register in the way, so the bench samples 1 ns after applying them. The bench models the pad as the driven value when the enable is high and as the outside level otherwise, so loopback results arrive in that same delta.

// File: rtl/srm_pkg.sv
package srm_pkg;
    localparam int FIELD_W        = 5;
    localparam int REG_W          = 32;
    localparam int FIELDS_PER_REG = REG_W / FIELD_W;
    localparam int CODE_LOW       = 0;
    localparam int CODE_HIGH      = 1;
    localparam int CODE_BASE      = 2;
endpackage

// File: rtl/srm_cfg_regs.sv
module srm_cfg_regs
    import srm_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 3,
    parameter int NUM_DEST = 48,
    parameter logic [NUM_REGS*REG_W-1:0] RST_IMAGE = '0
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [REG_W-1:0]                  wdata,
    output logic [REG_W-1:0]                  rdata,
    output logic [NUM_DEST-1:0][FIELD_W-1:0]  fields
);
    localparam int USED_W = FIELDS_PER_REG * FIELD_W;
    localparam logic [REG_W-1:0] DATA_MASK = {REG_W{1'b1}} >> (REG_W - USED_W);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] bank;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (we && (int'(addr) == r)) begin
                st_d.bank[r] = wdata & DATA_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= regs_t'(RST_IMAGE);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (int'(addr) == r) begin
                rdata = st_q.bank[r];
            end
        end
    end

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_field
        assign fields[d] = st_q.bank[d / FIELDS_PER_REG][(d % FIELDS_PER_REG) * FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/srm_src_mux.sv
module srm_src_mux #(
    parameter int N_SRC = 30,
    parameter int SEL_W = 5
)(
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    always_comb begin
        y = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (int'(sel) == i) begin
                y = src[i];
            end
        end
    end
endmodule

// File: rtl/srm_pin_buf.sv
module srm_pin_buf (
    input  logic drv_data,
    input  logic drv_en,
    input  logic pad_lvl,
    output logic pad_out,
    output logic pad_oe,
    output logic seen
);
    assign pad_out = drv_data;
    assign pad_oe  = drv_en;
    assign seen    = pad_lvl;
endmodule

// File: rtl/srm_route_core.sv
module srm_route_core
    import srm_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_PSRC = 6,
    parameter int NUM_PDST = 6,
    parameter int NUM_MISC = 2,
    parameter int NUM_DEST = 48
)(
    input  logic [NUM_DEST-1:0][FIELD_W-1:0] fields,
    input  logic [NUM_PINS-1:0]              pad_seen,
    input  logic [NUM_PSRC-1:0]              psrc,
    input  logic [NUM_PSRC-1:0]              psrc_en,
    output logic [NUM_PDST-1:0]              pdst,
    output logic [NUM_PINS-1:0]              pin_data,
    output logic [NUM_PINS-1:0]              pin_en
);
    localparam int DST_MISC   = NUM_PDST;
    localparam int DST_PIN_IN = NUM_PDST + NUM_MISC;
    localparam int DST_PIN_EN = DST_PIN_IN + NUM_PINS;
    localparam int N_SRC_P    = CODE_BASE + NUM_PINS + NUM_PSRC + NUM_MISC;
    localparam int N_SRC_D    = CODE_BASE + NUM_PSRC + NUM_MISC;

    logic [NUM_MISC-1:0] misc_o;
    logic [N_SRC_P-1:0]  src_p;
    logic [N_SRC_P-1:0]  src_node;
    logic [N_SRC_D-1:0]  src_d;
    logic [N_SRC_D-1:0]  src_e;

    // constant pair occupies codes 0 (low) and 1 (high)
    assign src_p    = {misc_o,           psrc,    pad_seen, 2'b10};
    assign src_node = {{NUM_MISC{1'b0}}, psrc,    pad_seen, 2'b10};
    assign src_d    = {misc_o,           psrc,              2'b10};
    assign src_e    = {misc_o,           psrc_en,           2'b10};

    for (genvar j = 0; j < NUM_PDST; j++) begin : g_pdst
        srm_src_mux #(.N_SRC(N_SRC_P), .SEL_W(FIELD_W)) u_mux (
            .src (src_p),
            .sel (fields[j]),
            .y   (pdst[j])
        );
    end

    for (genvar m = 0; m < NUM_MISC; m++) begin : g_misc
        srm_src_mux #(.N_SRC(N_SRC_P), .SEL_W(FIELD_W)) u_mux (
            .src (src_node),
            .sel (fields[DST_MISC + m]),
            .y   (misc_o[m])
        );
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        srm_src_mux #(.N_SRC(N_SRC_D), .SEL_W(FIELD_W)) u_data (
            .src (src_d),
            .sel (fields[DST_PIN_IN + i]),
            .y   (pin_data[i])
        );
        srm_src_mux #(.N_SRC(N_SRC_D), .SEL_W(FIELD_W)) u_en (
            .src (src_e),
            .sel (fields[DST_PIN_EN + i]),
            .y   (pin_en[i])
        );
    end
endmodule

// File: rtl/sig_route_matrix.sv
module sig_route_matrix
    import srm_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_PSRC = 6,
    parameter int NUM_PDST = 6,
    parameter int NUM_MISC = 2,
    localparam int NUM_DEST = NUM_PDST + NUM_MISC + 2 * NUM_PINS,
    localparam int NUM_REGS = (NUM_DEST + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic [NUM_PSRC-1:0] periph_src,
    input  logic [NUM_PSRC-1:0] periph_src_en,
    output logic [NUM_PDST-1:0] periph_dst,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int DST_MISC   = NUM_PDST;
    localparam int DST_PIN_IN = NUM_PDST + NUM_MISC;
    localparam int DST_PIN_EN = DST_PIN_IN + NUM_PINS;

    function automatic logic [NUM_REGS*REG_W-1:0] build_rst_image();
        logic [NUM_REGS*REG_W-1:0] img;
        int code;
        img = '0;
        for (int d = 0; d < NUM_DEST; d++) begin
            if (d < DST_MISC) begin
                code = CODE_BASE + (d % NUM_PINS);
            end else if (d < DST_PIN_IN) begin
                code = CODE_LOW;
            end else if (d < DST_PIN_EN) begin
                code = CODE_BASE + ((d - DST_PIN_IN) % NUM_PSRC);
            end else begin
                code = CODE_BASE + ((d - DST_PIN_EN) % NUM_PSRC);
            end
            img[(d / FIELDS_PER_REG) * REG_W + (d % FIELDS_PER_REG) * FIELD_W +: FIELD_W] = FIELD_W'(code);
        end
        return img;
    endfunction

    localparam logic [NUM_REGS*REG_W-1:0] RST_IMAGE = build_rst_image();

    logic [NUM_DEST-1:0][FIELD_W-1:0] cfg_fields;
    logic [NUM_PINS-1:0]              pad_seen;
    logic [NUM_PINS-1:0]              pin_data;
    logic [NUM_PINS-1:0]              pin_en;

    srm_cfg_regs #(
        .NUM_REGS  (NUM_REGS),
        .ADDR_W    (ADDR_W),
        .NUM_DEST  (NUM_DEST),
        .RST_IMAGE (RST_IMAGE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .fields (cfg_fields)
    );

    srm_route_core #(
        .NUM_PINS (NUM_PINS),
        .NUM_PSRC (NUM_PSRC),
        .NUM_PDST (NUM_PDST),
        .NUM_MISC (NUM_MISC),
        .NUM_DEST (NUM_DEST)
    ) u_core (
        .fields   (cfg_fields),
        .pad_seen (pad_seen),
        .psrc     (periph_src),
        .psrc_en  (periph_src_en),
        .pdst     (periph_dst),
        .pin_data (pin_data),
        .pin_en   (pin_en)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_buf
        srm_pin_buf u_buf (
            .drv_data (pin_data[i]),
            .drv_en   (pin_en[i]),
            .pad_lvl  (pad_in[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i]),
            .seen     (pad_seen[i])
        );
    end
endmodule

// File: rtl/srm_checker.sv
module srm_checker
    import srm_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_PSRC = 6,
    parameter int NUM_PDST = 6,
    parameter int NUM_MISC = 2,
    parameter int NUM_DEST = 48,
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 3
)(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             cfg_we,
    input logic [ADDR_W-1:0]                cfg_addr,
    input logic [REG_W-1:0]                 cfg_wdata,
    input logic [REG_W-1:0]                 cfg_rdata,
    input logic [NUM_DEST-1:0][FIELD_W-1:0] cfg_fields,
    input logic [NUM_PDST-1:0]              periph_dst,
    input logic [NUM_PINS-1:0]              pad_in,
    input logic [NUM_PINS-1:0]              pad_out,
    input logic [NUM_PINS-1:0]              pad_oe
);
    localparam int DST_PIN_IN = NUM_PDST + NUM_MISC;
    localparam int DST_PIN_EN = DST_PIN_IN + NUM_PINS;
    localparam int N_SRC_P    = CODE_BASE + NUM_PINS + NUM_PSRC + NUM_MISC;
    localparam logic [REG_W-1:0] DATA_MASK = {REG_W{1'b1}} >> (REG_W - FIELDS_PER_REG * FIELD_W);

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_addr) < NUM_REGS)) |=>
        ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == ($past(cfg_wdata) & DATA_MASK)))); // R4

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_fields)); // R4

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        AST_EN_CONST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg_fields[DST_PIN_EN + i]) == CODE_LOW) |-> !pad_oe[i]); // R7
        AST_EN_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg_fields[DST_PIN_EN + i]) == CODE_HIGH) |-> pad_oe[i]); // R1
        AST_DATA_CONST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg_fields[DST_PIN_IN + i]) == CODE_LOW) |-> !pad_out[i]); // R1
        AST_DATA_OOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg_fields[DST_PIN_IN + i]) >= CODE_BASE + NUM_PSRC + NUM_MISC) |-> !pad_out[i]); // R6
    end

    for (genvar j = 0; j < NUM_PDST; j++) begin : g_dst_chk
        AST_DST_OOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg_fields[j]) >= N_SRC_P) |-> !periph_dst[j]); // R5
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_loop
            AST_PAD_LOOPBACK: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(cfg_fields[j]) == CODE_BASE + i) |-> (periph_dst[j] == pad_in[i])); // R2
        end
    end
endmodule

bind sig_route_matrix srm_checker #(
    .NUM_PINS (NUM_PINS),
    .NUM_PSRC (NUM_PSRC),
    .NUM_PDST (NUM_PDST),
    .NUM_MISC (NUM_MISC),
    .NUM_DEST (NUM_DEST),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .cfg_fields (cfg_fields),
    .periph_dst (periph_dst),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/sig_route_matrix_bench.sv
`timescale 1ns/1ps
module sig_route_matrix_bench;
    localparam int NP = 20;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [5:0]  psrc = '0;
    logic [5:0]  psrc_en = '0;
    logic [5:0]  pdst;
    logic [NP-1:0] pad_in, pad_out, pad_oe;
    logic [NP-1:0] ext = '0;
    logic [1:0]  mval = '0;
    logic [31:0] shadow [NR];
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // pad model: driven value when enabled, outside level otherwise
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    sig_route_matrix u_sig_route_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_src(psrc),
        .periph_src_en(psrc_en), .periph_dst(pdst), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] default_reg(input int r);
        logic [31:0] v = '0;
        for (int f = 0; f < 6; f++) begin
            int d = r * 6 + f;
            int code;
            if (d < 6) code = 2 + d;
            else if (d < 8) code = 0;
            else if (d < 28) code = 2 + ((d - 8) % 6);
            else code = 2 + ((d - 28) % 6);
            v[f*5 +: 5] = 5'(code);
        end
        return v;
    endfunction

    function automatic logic exp_p(input int code);
        if (code == 1) return 1'b1;
        if (code >= 2 && code <= 21) return ext[code-2];
        if (code >= 22 && code <= 27) return psrc[code-22];
        if (code == 28 || code == 29) return mval[code-28];
        return 1'b0;
    endfunction

    function automatic logic exp_d(input int code, input logic [5:0] s);
        if (code == 1) return 1'b1;
        if (code >= 2 && code <= 7) return s[code-2];
        if (code == 8 || code == 9) return mval[code-8];
        return 1'b0;
    endfunction

    task automatic wr_reg(input int a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        shadow[a] = v & 32'h3FFF_FFFF;
    endtask

    task automatic set_field(input int d, input int code);
        logic [31:0] v = shadow[d / 6];
        v[(d % 6)*5 +: 5] = 5'(code);
        wr_reg(d / 6, v);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset image of every register
        for (int r = 0; r < NR; r++) begin
            cfg_addr = 3'(r); #1;
            chk("R9 reset register", cfg_rdata, default_reg(r));
            shadow[r] = default_reg(r);
        end
        // R9: default pad routing to peripheral signals
        psrc_en = 6'b000101; psrc = 6'b110010; #1;
        for (int i = 0; i < NP; i++) begin
            chk("R9 default pad enable", {31'd0, pad_oe[i]}, {31'd0, psrc_en[i % 6]});
            chk("R9 default pad data", {31'd0, pad_out[i]}, {31'd0, psrc[i % 6]});
        end

        // R3 R4: clear everything, then readback patterns
        for (int r = 1; r < NR; r++) wr_reg(r, 32'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h1234_5678; #1;
        chk("R4 no effect before edge", cfg_rdata, default_reg(0));
        @(negedge clk); cfg_we = 1'b0; #1;
        chk("R4 effect after edge", cfg_rdata, 32'h1234_5678 & 32'h3FFF_FFFF);
        for (int r = 0; r < 5; r++) begin
            logic [31:0] p = 32'hC5A3_96E1 ^ (32'(r) * 32'h1357_9BDF);
            if (r == 4) p = p & 32'hC00F_FFFF;
            wr_reg(r, p);
            cfg_addr = 3'(r); #1;
            chk("R3 readback masked", cfg_rdata, p & 32'h3FFF_FFFF);
        end
        for (int r = 0; r < 5; r++) wr_reg(r, 32'd0);
        for (int r = 5; r < NR; r++) begin
            logic [31:0] p = 32'hF0E1_D2C3 ^ (32'(r) * 32'h0246_8ACE);
            wr_reg(r, p);
            cfg_addr = 3'(r); #1;
            chk("R3 readback masked", cfg_rdata, p & 32'h3FFF_FFFF);
        end
        for (int r = 5; r < NR; r++) wr_reg(r, 32'd0);

        // R5 R2: peripheral-input code sweep on destination 2, all pads inputs
        set_field(6, 1); set_field(7, 0); mval = 2'b01;
        psrc = 6'b101101;
        for (int code = 0; code < 32; code++) begin
            set_field(2, code);
            ext = 20'hA5C39; #1;
            chk("R5 peripheral code sweep", {31'd0, pdst[2]}, {31'd0, exp_p(code)});
            ext = ~20'hA5C39; #1;
            chk("R5 peripheral code sweep inverted pads", {31'd0, pdst[2]}, {31'd0, exp_p(code)});
        end

        // R8: node 0 sweep observed through destination 0 (code 28)
        set_field(7, 1); mval = 2'b10;
        set_field(0, 28);
        for (int code = 0; code < 32; code++) begin
            logic e;
            set_field(6, code);
            ext = 20'h3C5A6; #1;
            e = (code == 28 || code == 29) ? 1'b0 : exp_p(code);
            chk("R8 node source sweep", {31'd0, pdst[0]}, {31'd0, e});
        end
        set_field(6, 1); set_field(7, 0); mval = 2'b01;

        // R6 R2: pad data sweep on pad 3 with enable high, loopback to destination 2
        set_field(31, 1);
        set_field(2, 5);
        psrc = 6'b011001; ext = '0;
        for (int code = 0; code < 32; code++) begin
            set_field(11, code); #1;
            chk("R6 pad data sweep", {31'd0, pad_out[3]}, {31'd0, exp_d(code, psrc)});
            chk("R2 loopback driven pad", {31'd0, pdst[2]}, {31'd0, exp_d(code, psrc)});
        end
        set_field(31, 0); set_field(11, 0);

        // R7 R2: pad enable sweep on pad 5, data high, outside level low
        set_field(13, 1);
        set_field(2, 7);
        psrc_en = 6'b011010; ext = '0;
        for (int code = 0; code < 32; code++) begin
            set_field(33, code); #1;
            chk("R7 pad enable sweep", {31'd0, pad_oe[5]}, {31'd0, exp_d(code, psrc_en)});
            chk("R2 loopback follows pad level", {31'd0, pdst[2]}, {31'd0, exp_d(code, psrc_en)});
        end
        set_field(33, 0); set_field(13, 0);

        // R10: all peripheral inputs from pad 9
        for (int j = 0; j < 6; j++) set_field(j, 11);
        for (int b = 0; b < 2; b++) begin
            ext = '0; ext[9] = 1'(b); #1;
            chk("R10 fan-out", {26'd0, pdst}, {26'd0, {6{1'(b)}}});
        end

        // R11 R2: pad 7 direction from pad 1 through node 0
        set_field(6, 3); set_field(29, 0); set_field(35, 8);
        set_field(15, 3); set_field(0, 9);
        for (int k = 0; k < 8; k++) begin
            logic e1, e7, s1;
            e1 = k[0]; e7 = k[1]; s1 = k[2];
            ext = '0; ext[1] = e1; ext[7] = e7; psrc = '0; psrc[1] = s1; #1;
            chk("R11 direction follows pad 1", {31'd0, pad_oe[7]}, {31'd0, e1});
            chk("R2 pad 7 loopback", {31'd0, pdst[0]}, {31'd0, e1 ? s1 : e7});
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule